// File: doc/BRIEF.md
# Double-Buffered Host-Processor Data Mailbox

This block carries 24-bit words in both directions between an embedded processor and an external host. Each direction is a two-stage pipeline. The processor writes a whole word into its outbound register, and the host collects it as three bytes. The host writes three bytes, and the processor reads them as one word. A word moves forward from one stage to the next by itself, in the first cycle where the sending stage holds data and the receiving stage is free. No side ever waits on a handshake.

The processor sees a control register holding two interrupt enables and an interface enable. It also sees a status word: outbound empty, inbound full and a sticky access-error bit. The status word reaches it two cycles after the flags change. The host sees its own two flags directly. An interrupt request goes out for each direction. A hardware reset, a software reset and a stop reset all return the block to its idle state. Clearing the interface enable resets only the processor-side flags.

Top module: `hmbx_top`

## Requirements
- R1: A processor word write while the outbound-empty flag is set stores the word and clears outbound-empty at that clock edge.
- R2: When the interface is enabled, outbound-empty is clear and the host receive-full flag is clear, the word moves to the host receive stage at the next edge. That edge sets host receive-full and sets outbound-empty again. While the host stage stays full, the word waits.
- R3: A host read returns one byte one cycle later: host_addr 0 selects bits 23:16, 1 selects bits 15:8, 2 selects bits 7:0. Only a read at address 2 clears host receive-full. Reads at 0 and 1 leave it set.
- R4: Host writes at address 0 and 1 only stage the high and middle bytes. A write at address 2 while host transmit-empty is set commits the word {high, middle, written byte} and clears host transmit-empty. A write at address 2 while host transmit-empty is clear is ignored and leaves the pending word unchanged.
- R5: When the interface is enabled, host transmit-empty is clear and inbound-full is clear, the pending host word loads the processor receive word at the next edge. That edge sets inbound-full and host transmit-empty.
- R6: A processor read while inbound-full is set clears inbound-full. cpu_rx_data holds the received word until the next inbound move.
- R7: A processor write while outbound-empty is clear, or a read while inbound-full is clear, is ignored, and the sticky error bit is set. Data already in flight is delivered unchanged.
- R8: cpu_status is {error, inbound-full, outbound-empty} with outbound-empty in bit 0. It shows the flag values two clock edges after they change.
- R9: irq_tx is a register of (enable & tx-interrupt-enable & outbound-empty). irq_rx is a register of (enable & rx-interrupt-enable & inbound-full). Each follows its flag by one edge.
- R10: While the interface enable is clear, the processor-side flags are held at outbound-empty=1, inbound-full=0 and error=0. No word moves, processor accesses are ignored, and both interrupt requests are low.
- R11: rst, soft_rst and stop_rst each bring the block to its idle state: both empty flags set, both full flags clear, error clear, and control cleared (disabled, both interrupt enables off). cpu_ctl_wdata bit 0 is the tx interrupt enable, bit 1 the rx interrupt enable, bit 2 the interface enable.
- R12: When an outbound move and an inbound move are both eligible in the same cycle, both complete at that edge with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset, active high |
| stop_rst | input | 1 | Synchronous stop reset, active high |
| cpu_ctl_wr | input | 1 | Control register write strobe |
| cpu_ctl_wdata | input | 3 | {interface enable, rx irq enable, tx irq enable} |
| cpu_tx_wr | input | 1 | Outbound word write strobe |
| cpu_tx_data | input | 24 | Outbound word |
| cpu_rx_rd | input | 1 | Inbound word read strobe |
| cpu_rx_data | output | 24 | Inbound word |
| cpu_status | output | 3 | {error, inbound-full, outbound-empty}, delayed two cycles |
| host_wr | input | 1 | Host byte write strobe |
| host_rd | input | 1 | Host byte read strobe |
| host_addr | input | 2 | Byte select: 0 high, 1 middle, 2 low |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, one cycle after the read |
| host_rx_full | output | 1 | Host receive stage holds a word |
| host_tx_empty | output | 1 | Host transmit stage is free |
| irq_tx | output | 1 | Outbound interrupt request |
| irq_rx | output | 1 | Inbound interrupt request |

## Verification
Directed sequences first send a single word through an idle pipeline. The status delay shows there as a one-cycle dip of outbound-empty, which separates a correct two-edge delay from a one-edge or three-edge one. Back-to-back words while the far stage is full show whether a word waits or is overwritten. A third word written into a full pipe tells a rejected access apart from one that corrupts data. Same-cycle commits in both directions catch interference between the paths. A random phase with seeded arbitrary words and random access order then checks that every word arrives once, in order and intact, in each direction.

// File: rtl/hmbx_pkg.sv
`timescale 1ns/1ps
package hmbx_pkg;
  typedef struct packed {
    logic err;
    logic rx_full;
    logic tx_empty;
  } cpu_stat_t;

  localparam int unsigned STAT_W   = 3;
  localparam int unsigned CTL_W    = 3;
  localparam int unsigned CTL_TXIE = 0;
  localparam int unsigned CTL_RXIE = 1;
  localparam int unsigned CTL_EN   = 2;
  localparam logic [STAT_W-1:0] STAT_IDLE = 3'b001;
endpackage

// File: rtl/hmbx_delay.sv
`timescale 1ns/1ps
module hmbx_delay #(
  parameter int unsigned W     = 3,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[i] <= RST_VAL;
        else     pipe[i] <= pipe[i-1];
      end
    end
  end

  assign q = pipe[DEPTH-1];
endmodule

// File: rtl/hmbx_out_path.sv
`timescale 1ns/1ps
module hmbx_out_path #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NBYTES = DATA_W / BYTE_W,
  localparam int unsigned HA_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              host_rd,
  input  logic [HA_W-1:0]   host_addr,
  output logic              tx_empty,
  output logic [DATA_W-1:0] tx_word,
  output logic              h_rx_full,
  output logic [DATA_W-1:0] h_rx_word,
  output logic              wr_reject
);
  localparam logic [HA_W-1:0] LOW_SEL = HA_W'(NBYTES - 1);

  logic wr_ok, move, low_rd;

  assign wr_ok     = en & cpu_wr & tx_empty;
  assign wr_reject = en & cpu_wr & ~tx_empty;
  assign move      = en & ~tx_empty & ~h_rx_full;
  assign low_rd    = host_rd & (host_addr == LOW_SEL);

  // processor-side stage
  always_ff @(posedge clk) begin
    if (rst || !en)  tx_empty <= 1'b1;
    else if (wr_ok)  tx_empty <= 1'b0;
    else if (move)   tx_empty <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        tx_word <= '0;
    else if (wr_ok) tx_word <= cpu_wdata;
  end

  // host-side stage
  always_ff @(posedge clk) begin
    if (rst)         h_rx_full <= 1'b0;
    else if (move)   h_rx_full <= 1'b1;
    else if (low_rd) h_rx_full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       h_rx_word <= '0;
    else if (move) h_rx_word <= tx_word;
  end
endmodule

// File: rtl/hmbx_in_path.sv
`timescale 1ns/1ps
module hmbx_in_path #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned NBYTES = DATA_W / BYTE_W,
  localparam int unsigned HA_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              host_wr,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              cpu_rd,
  output logic              h_tx_empty,
  output logic [DATA_W-1:0] h_tx_word,
  output logic              rx_full,
  output logic [DATA_W-1:0] rx_word,
  output logic              rd_reject
);
  localparam logic [HA_W-1:0] LOW_SEL = HA_W'(NBYTES - 1);

  logic [BYTE_W-1:0] stage [NBYTES-1];
  logic [DATA_W-1:0] commit_word;
  logic              commit, move, rd_ok;

  // upper bytes are staged; the low byte completes the word
  for (genvar i = 0; i < NBYTES - 1; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else if (host_wr && host_addr == HA_W'(i)) stage[i] <= host_wdata;
    end
    assign commit_word[DATA_W-1-i*BYTE_W -: BYTE_W] = stage[i];
  end
  assign commit_word[BYTE_W-1:0] = host_wdata;

  assign commit    = host_wr & (host_addr == LOW_SEL) & h_tx_empty;
  assign move      = en & ~h_tx_empty & ~rx_full;
  assign rd_ok     = en & cpu_rd & rx_full;
  assign rd_reject = en & cpu_rd & ~rx_full;

  // host-side stage
  always_ff @(posedge clk) begin
    if (rst)         h_tx_empty <= 1'b1;
    else if (commit) h_tx_empty <= 1'b0;
    else if (move)   h_tx_empty <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         h_tx_word <= '0;
    else if (commit) h_tx_word <= commit_word;
  end

  // processor-side stage
  always_ff @(posedge clk) begin
    if (rst || !en) rx_full <= 1'b0;
    else if (move)  rx_full <= 1'b1;
    else if (rd_ok) rx_full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)       rx_word <= '0;
    else if (move) rx_word <= h_tx_word;
  end
endmodule

// File: rtl/hmbx_top.sv
`timescale 1ns/1ps
module hmbx_top
  import hmbx_pkg::*;
#(
  parameter int unsigned DATA_W   = 24,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned STAT_DLY = 2,
  localparam int unsigned NBYTES  = DATA_W / BYTE_W,
  localparam int unsigned HA_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              stop_rst,
  input  logic              cpu_ctl_wr,
  input  logic [CTL_W-1:0]  cpu_ctl_wdata,
  input  logic              cpu_tx_wr,
  input  logic [DATA_W-1:0] cpu_tx_data,
  input  logic              cpu_rx_rd,
  output logic [DATA_W-1:0] cpu_rx_data,
  output logic [STAT_W-1:0] cpu_status,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic              host_rx_full,
  output logic              host_tx_empty,
  output logic              irq_tx,
  output logic              irq_rx
);
  logic              any_rst;
  logic [CTL_W-1:0]  ctl;
  logic              en, tx_ie, rx_ie;
  logic              p_tx_empty, p_rx_full, err;
  logic              h_rx_full, h_tx_empty;
  logic              wr_reject, rd_reject;
  logic [DATA_W-1:0] tx_word, h_rx_word, h_tx_word, rx_word;
  logic [BYTE_W-1:0] h_bytes [NBYTES];
  cpu_stat_t         stat_now;

  assign any_rst = rst | soft_rst | stop_rst;
  assign en      = ctl[CTL_EN];
  assign tx_ie   = ctl[CTL_TXIE];
  assign rx_ie   = ctl[CTL_RXIE];

  always_ff @(posedge clk) begin
    if (any_rst)         ctl <= '0;
    else if (cpu_ctl_wr) ctl <= cpu_ctl_wdata;
  end

  hmbx_out_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_out (
    .clk       (clk),
    .rst       (any_rst),
    .en        (en),
    .cpu_wr    (cpu_tx_wr),
    .cpu_wdata (cpu_tx_data),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .tx_empty  (p_tx_empty),
    .tx_word   (tx_word),
    .h_rx_full (h_rx_full),
    .h_rx_word (h_rx_word),
    .wr_reject (wr_reject)
  );

  hmbx_in_path #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_in (
    .clk        (clk),
    .rst        (any_rst),
    .en         (en),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .cpu_rd     (cpu_rx_rd),
    .h_tx_empty (h_tx_empty),
    .h_tx_word  (h_tx_word),
    .rx_full    (p_rx_full),
    .rx_word    (rx_word),
    .rd_reject  (rd_reject)
  );

  // sticky access error, part of the processor-side flags
  always_ff @(posedge clk) begin
    if (any_rst || !en)           err <= 1'b0;
    else if (wr_reject || rd_reject) err <= 1'b1;
  end

  assign stat_now.err      = err;
  assign stat_now.rx_full  = p_rx_full;
  assign stat_now.tx_empty = p_tx_empty;

  hmbx_delay #(.W(STAT_W), .DEPTH(STAT_DLY), .RST_VAL(STAT_IDLE)) u_stat_dly (
    .clk (clk),
    .rst (any_rst),
    .d   (stat_now),
    .q   (cpu_status)
  );

  always_ff @(posedge clk) begin
    if (any_rst) begin
      irq_tx <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      irq_tx <= en & tx_ie & p_tx_empty;
      irq_rx <= en & rx_ie & p_rx_full;
    end
  end

  // host byte view, index 0 is the most significant byte
  for (genvar i = 0; i < NBYTES; i++) begin : g_hbyte
    assign h_bytes[i] = h_rx_word[DATA_W-1-i*BYTE_W -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (any_rst) host_rdata <= '0;
    else if (host_rd) begin
      if (32'(host_addr) < NBYTES) host_rdata <= h_bytes[host_addr];
      else                         host_rdata <= '0;
    end
  end

  assign cpu_rx_data   = rx_word;
  assign host_rx_full  = h_rx_full;
  assign host_tx_empty = h_tx_empty;
endmodule

// File: rtl/hmbx_chk.sv
`timescale 1ns/1ps
module hmbx_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              stop_rst,
  input logic              en,
  input logic              tx_ie,
  input logic              rx_ie,
  input logic              p_tx_empty,
  input logic              p_rx_full,
  input logic              err,
  input logic              h_tx_empty,
  input logic              h_rx_full,
  input logic              cpu_tx_wr,
  input logic              cpu_rx_rd,
  input logic [DATA_W-1:0] tx_word,
  input logic [DATA_W-1:0] h_rx_word,
  input logic [DATA_W-1:0] h_tx_word,
  input logic [DATA_W-1:0] rx_word,
  input logic [2:0]        cpu_status,
  input logic              irq_tx,
  input logic              irq_rx
);
  logic       any_rst;
  logic [1:0] since;

  assign any_rst = rst | soft_rst | stop_rst;

  always_ff @(posedge clk) begin
    if (any_rst)        since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  a_r2_out_move: assert property (@(posedge clk) disable iff (any_rst)
    (en && !p_tx_empty && !h_rx_full) |=>
      (h_rx_full && p_tx_empty && h_rx_word == $past(tx_word)));

  a_r5_in_move: assert property (@(posedge clk) disable iff (any_rst)
    (en && !h_tx_empty && !p_rx_full) |=>
      (p_rx_full && h_tx_empty && rx_word == $past(h_tx_word)));

  a_r6_read_clears: assert property (@(posedge clk) disable iff (any_rst)
    (en && cpu_rx_rd && p_rx_full) |=> !p_rx_full);

  a_r7_wr_ignored: assert property (@(posedge clk) disable iff (any_rst)
    (en && cpu_tx_wr && !p_tx_empty) |=> (err && $stable(tx_word)));

  a_r8_status_delay: assert property (@(posedge clk) disable iff (any_rst)
    (since >= 2'd2) |-> (cpu_status == $past({err, p_rx_full, p_tx_empty}, 2)));

  a_r9_irq_follow: assert property (@(posedge clk) disable iff (any_rst)
    (since >= 2'd1) |->
      (irq_tx == $past(en && tx_ie && p_tx_empty) &&
       irq_rx == $past(en && rx_ie && p_rx_full)));

  a_r10_disabled: assert property (@(posedge clk) disable iff (any_rst)
    !en |=> (p_tx_empty && !p_rx_full && !err && !irq_tx && !irq_rx));

  a_r11_reset_idle: assert property (@(posedge clk) disable iff (rst)
    (soft_rst || stop_rst) |=>
      (p_tx_empty && !p_rx_full && h_tx_empty && !h_rx_full &&
       !en && !tx_ie && !rx_ie && !err));
endmodule

bind hmbx_top hmbx_chk #(.DATA_W(DATA_W)) i_hmbx_chk (
  .clk        (clk),
  .rst        (rst),
  .soft_rst   (soft_rst),
  .stop_rst   (stop_rst),
  .en         (en),
  .tx_ie      (tx_ie),
  .rx_ie      (rx_ie),
  .p_tx_empty (p_tx_empty),
  .p_rx_full  (p_rx_full),
  .err        (err),
  .h_tx_empty (h_tx_empty),
  .h_rx_full  (h_rx_full),
  .cpu_tx_wr  (cpu_tx_wr),
  .cpu_rx_rd  (cpu_rx_rd),
  .tx_word    (tx_word),
  .h_rx_word  (h_rx_word),
  .h_tx_word  (h_tx_word),
  .rx_word    (rx_word),
  .cpu_status (cpu_status),
  .irq_tx     (irq_tx),
  .irq_rx     (irq_rx)
);

// File: tb/test_hmbx_top.sv
`timescale 1ns/1ps
module test_hmbx_top;
  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1, soft_rst = 1'b0, stop_rst = 1'b0;
  logic        cpu_ctl_wr = 1'b0;
  logic [2:0]  cpu_ctl_wdata = '0;
  logic        cpu_tx_wr = 1'b0;
  logic [23:0] cpu_tx_data = '0;
  logic        cpu_rx_rd = 1'b0;
  logic [23:0] cpu_rx_data;
  logic [2:0]  cpu_status;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rx_full, host_tx_empty, irq_tx, irq_rx;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] out_q[$];
  logic [23:0] in_q[$];

  always #(CLK_NS/2) clk = ~clk;

  hmbx_top i_hmbx_top (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_rst(stop_rst),
    .cpu_ctl_wr(cpu_ctl_wr), .cpu_ctl_wdata(cpu_ctl_wdata),
    .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
    .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data), .cpu_status(cpu_status),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rx_full(host_rx_full), .host_tx_empty(host_tx_empty),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  // status word from flags: {err, rx_full, tx_empty}
  function automatic logic [2:0] stat(input logic e, input logic f, input logic m);
    return {e, f, m};
  endfunction

  function automatic logic [7:0] byte_of(input logic [23:0] w, input int i);
    return w[23-8*i -: 8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic ctl_write(input logic [2:0] v);
    cpu_ctl_wr = 1'b1; cpu_ctl_wdata = v;
    cycle();
    cpu_ctl_wr = 1'b0;
  endtask

  task automatic cpu_write(input logic [23:0] w);
    cpu_tx_wr = 1'b1; cpu_tx_data = w;
    cycle();
    cpu_tx_wr = 1'b0;
    wait_n(2);
  endtask

  task automatic cpu_read();
    cpu_rx_rd = 1'b1;
    cycle();
    cpu_rx_rd = 1'b0;
    wait_n(2);
  endtask

  task automatic host_write_byte(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    cycle();
    host_wr = 1'b0;
  endtask

  task automatic host_write_word(input logic [23:0] w);
    for (int i = 0; i < 3; i++) host_write_byte(2'(i), byte_of(w, i));
  endtask

  task automatic host_read_byte(input logic [1:0] a, output logic [7:0] d);
    host_rd = 1'b1; host_addr = a;
    cycle();
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic host_read_word(output logic [23:0] w);
    logic [7:0] b;
    for (int i = 0; i < 3; i++) begin
      host_read_byte(2'(i), b);
      w[23-8*i -: 8] = b;
    end
  endtask

  task automatic pulse(input int which);
    if (which == 0) soft_rst = 1'b1; else stop_rst = 1'b1;
    cycle();
    soft_rst = 1'b0; stop_rst = 1'b0;
    cycle();
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] w, w1, w2, w3, w4, v1, v2, v3, v4;
    logic [7:0]  b;
    void'($urandom(32'd4242));
    w1 = 24'hA1B2C3; w2 = 24'h102030; w3 = 24'h445566; w4 = 24'hDEAD01;
    v1 = 24'h0F1E2D; v2 = 24'h778899; v3 = 24'h123456; v4 = 24'hFFEE00;

    wait_n(4);
    rst = 1'b0;
    cycle();

    // R11: hardware reset state
    check("R11 status", cpu_status, stat(0, 0, 1));
    check("R11 host_tx_empty", host_tx_empty, 1);
    check("R11 host_rx_full", host_rx_full, 0);
    check("R11 irq", {irq_tx, irq_rx}, 2'b00);

    // R10: disabled after reset, a write does not move
    cpu_write(w4);
    wait_n(2);
    check("R10 no move when disabled", host_rx_full, 0);
    check("R10 status held", cpu_status, stat(0, 0, 1));

    ctl_write(3'b100);
    cycle();

    // R1 R2 R8: single word through idle pipe, status timing
    cpu_tx_wr = 1'b1; cpu_tx_data = w1;
    cycle();                       // edge k
    cpu_tx_wr = 1'b0;
    check("R8 status old after k", cpu_status, stat(0, 0, 1));
    cycle();                       // k+1
    check("R2 host full after move", host_rx_full, 1);
    check("R8 status old after k+1", cpu_status, stat(0, 0, 1));
    cycle();                       // k+2
    check("R1 R8 tx_empty cleared seen", cpu_status, stat(0, 0, 0));
    cycle();                       // k+3
    check("R2 R8 tx_empty set again seen", cpu_status, stat(0, 0, 1));

    // R3: byte order, only low read clears
    host_read_byte(2'd0, b);
    check("R3 high byte", b, byte_of(w1, 0));
    check("R3 high read keeps full", host_rx_full, 1);
    host_read_byte(2'd1, b);
    check("R3 mid byte", b, byte_of(w1, 1));
    check("R3 mid read keeps full", host_rx_full, 1);
    host_read_byte(2'd2, b);
    check("R3 low byte", b, byte_of(w1, 2));
    check("R3 low read clears full", host_rx_full, 0);

    // R7: rejected write while outbound full
    cpu_write(w2);                 // moves to host
    cpu_write(w3);                 // waits, host full
    check("R2 word waits while host full", cpu_status, stat(0, 0, 0));
    cpu_write(w4);                 // rejected
    cycle();
    check("R7 write error sticky", cpu_status, stat(1, 0, 0));
    host_read_word(w);
    check("R2 first word", w, w2);
    cycle();
    check("R2 next word moved", host_rx_full, 1);
    host_read_word(w);
    check("R7 in-flight word intact", w, w3);
    wait_n(3);
    check("R7 nothing else sent", host_rx_full, 0);

    // R4 R5 R6: inbound
    host_write_byte(2'd0, byte_of(v1, 0));
    host_write_byte(2'd1, byte_of(v1, 1));
    host_wr = 1'b1; host_addr = 2'd2; host_wdata = byte_of(v1, 2);
    cycle();                       // commit edge
    host_wr = 1'b0;
    check("R4 commit clears host_tx_empty", host_tx_empty, 0);
    cycle();
    check("R5 move sets host_tx_empty", host_tx_empty, 1);
    check("R5 inbound data", cpu_rx_data, v1);
    wait_n(2);
    check("R5 rx_full seen", cpu_status[1], 1);
    cpu_read();
    cycle();
    check("R6 read clears rx_full", cpu_status[1], 0);

    host_write_word(v2);           // moves
    cycle();
    host_write_word(v3);           // waits
    check("R4 second word pending", host_tx_empty, 0);
    host_write_word(v4);           // low write ignored
    check("R4 ignored write keeps pending", host_tx_empty, 0);
    check("R6 held word", cpu_rx_data, v2);
    cpu_read();
    check("R4 pending word intact", cpu_rx_data, v3);
    cpu_read();
    wait_n(2);
    check("R4 nothing extra", cpu_status[1], 0);

    // R11: soft reset clears error and control
    pulse(0);
    wait_n(2);
    check("R11 soft reset status", cpu_status, stat(0, 0, 1));
    cpu_write(w4);
    wait_n(2);
    check("R11 soft reset disables", host_rx_full, 0);

    // R7: read while empty
    ctl_write(3'b100);
    cpu_read();
    cycle();
    check("R7 read error", cpu_status, stat(1, 0, 1));

    // R11 R9: stop reset, then interrupts
    pulse(1);
    wait_n(2);
    check("R11 stop reset status", cpu_status, stat(0, 0, 1));
    ctl_write(3'b101);
    cycle();
    check("R9 irq_tx on empty", irq_tx, 1);
    cpu_write(w1);                 // goes to host
    cpu_write(w2);                 // waits
    check("R9 irq_tx drops", irq_tx, 0);

    // R10: disable with data waiting
    ctl_write(3'b000);
    wait_n(3);
    check("R10 flags reset", cpu_status, stat(0, 0, 1));
    check("R10 irq low", {irq_tx, irq_rx}, 2'b00);
    ctl_write(3'b110);
    host_read_word(w);
    check("R10 earlier word", w, w1);
    wait_n(3);
    check("R10 dropped word not sent", host_rx_full, 0);

    // R9: rx interrupt
    check("R9 irq_rx idle", irq_rx, 0);
    host_write_word(v1);
    wait_n(2);
    check("R9 irq_rx on full", irq_rx, 1);
    cpu_read();
    check("R9 irq_rx drops", irq_rx, 0);

    // R12: both directions in one cycle
    host_write_byte(2'd0, byte_of(v4, 0));
    host_write_byte(2'd1, byte_of(v4, 1));
    cpu_tx_wr = 1'b1; cpu_tx_data = w3;
    host_wr = 1'b1; host_addr = 2'd2; host_wdata = byte_of(v4, 2);
    cycle();
    cpu_tx_wr = 1'b0; host_wr = 1'b0;
    cycle();
    check("R12 outbound done", host_rx_full, 1);
    check("R12 inbound done", host_tx_empty, 1);
    wait_n(2);
    check("R12 status", cpu_status, stat(0, 1, 1));
    check("R12 inbound data", cpu_rx_data, v4);
    host_read_word(w);
    check("R12 outbound data", w, w3);
    cpu_read();

    // random traffic both ways, R1 R2 R3 R4 R5 R6
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(3))
        0: if (cpu_status[0]) begin
             w = 24'($urandom);
             out_q.push_back(w);
             cpu_write(w);
           end
        1: if (host_rx_full) begin
             host_read_word(w);
             if (out_q.size() == 0) check("R2 random unexpected word", w, 0);
             else check("R2 random outbound", w, out_q.pop_front());
           end
        2: if (host_tx_empty) begin
             w = 24'($urandom);
             in_q.push_back(w);
             host_write_word(w);
           end
        default: if (cpu_status[1]) begin
             if (in_q.size() == 0) check("R5 random unexpected word", cpu_rx_data, 0);
             else check("R5 random inbound", cpu_rx_data, in_q.pop_front());
             cpu_read();
           end
      endcase
      cycle();
    end
    check("R7 no random error", cpu_status[2], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule